// File: doc/BRIEF.md
# Byte-Stream UART Register Front End

This block is the bus-facing half of a minimal serial port. A synchronous read/write port with a byte address reaches four 32-bit word registers: received data, data to send, a status word and a control word. Bytes from an external deserializer arrive on a valid/ready stream and are held in a small circular FIFO. Software drains the FIFO by reading the receive register; each read removes one byte.

A write to the transmit register sends the low byte out on a one-cycle strobe to an external serializer. The transmit side always reports empty. A sticky pending flag in the status word is raised by received data or by a transmit write. When the control enable bit is set, that flag drives a registered, level-sensitive interrupt line.

Bit-level serial timing, baud generation and line error detection are not part of this block. Their status bits are reserved and read as zero.

Top module: `serial_lite_regs`

## Requirements
- R1: The register is selected by byte address bits [3:2], and address bits [1:0] are ignored. Index 0 is receive data, 1 is transmit data, 2 is status and 3 is control. Read data appears on `bus_rdata` one clock after the read is sampled.
- R2: Status word bits: bit 0 is 1 when the FIFO holds at least one byte; bit 1 is 1 when it holds DEPTH (8) bytes; bit 2 is always 1; bit 4 is the pending flag. Bits 3, 5, 6, 7 and all higher bits read 0.
- R3: Reading the receive register returns the oldest held byte in bits [7:0], with zeros above, and removes it. Bytes come out in arrival order, across pointer wrap-around.
- R4: `rx_ready` is high only while fewer than DEPTH bytes are held. A byte offered while the FIFO is full is dropped, and the stored bytes are unchanged.
- R5: Reading the receive register while the FIFO is empty returns the byte still in the slot at the write pointer and leaves the FIFO empty.
- R6: A receive-register read and an accepted incoming byte in the same cycle both take effect.
- R7: A control write stores all 32 bits, which read back unchanged. If bit 1 is set, the write also empties the FIFO and returns the write pointer to slot 0. Bit 0 and bit 4 are stored like any other bit.
- R8: A transmit write drives `tx_strobe` high for exactly one cycle, starting the clock after the write, with `tx_byte` equal to write data bits [7:0]. The full written word reads back from index 1, and the write sets the pending flag.
- R9: The pending flag is set whenever the FIFO is non-empty and stays set after the FIFO drains. A status read returns the flag and then clears it, unless the FIFO still holds data.
- R10: `irq` equals the pending flag AND control bit 4. It is registered and changes on the clock edge that applies the causing event.
- R11: A write to the status register changes no state and pulses `wr_err` high for exactly one cycle.
- R12: After reset the FIFO is empty, control reads 0, pending is clear, `irq` is 0 and status reads 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address within the 16-byte window |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| rx_byte | input | 8 | Incoming byte from the deserializer |
| rx_valid | input | 1 | Incoming byte is valid |
| rx_ready | output | 1 | FIFO can accept a byte |
| tx_byte | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Level interrupt |
| wr_err | output | 1 | One-cycle pulse on a write to status |

## Verification
A wrong occupancy count shows at the ports within one read. `rx_ready` and status bits 0 and 1 change on the very next clock, and each receive read returns the wrong byte or the wrong order. A corrupted pointer shows in the data order across a wrap and in the stale byte returned by a read of an empty FIFO. A wrong pending flag appears on `irq` one edge after the event, and in bit 4 of the next status read. The sweep walks every fill level from 0 to 8 at every starting pointer offset, so off-by-one errors at wrap and at full reach the outputs.

// File: rtl/serial_lite_pkg.sv
package serial_lite_pkg;
  localparam int WIN_BYTES = 16;
  localparam int ADDR_W    = $clog2(WIN_BYTES);

  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_idx_e;

  // status bit positions
  localparam int ST_VALID   = 0;
  localparam int ST_FULL    = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_PEND    = 4;

  // control bit positions
  localparam int CT_RXRST = 1;
  localparam int CT_IE    = 4;
endpackage

// File: rtl/slr_rx_fifo.sv
module slr_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  input  logic              pop_req,
  output logic [BYTE_W-1:0] dout,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cnt_nxt,
  output logic              ready
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr;
  logic [PTR_W-1:0]  rptr;
  logic              push_ok;
  logic              pop_ok;

  assign ready   = (cnt < CNT_W'(DEPTH));
  assign push_ok = push && ready;
  assign pop_ok  = pop_req && (cnt != '0);
  assign rptr    = wptr - cnt[PTR_W-1:0];
  assign cnt_nxt = clr ? '0 : (cnt + CNT_W'(push_ok) - CNT_W'(pop_ok));

  // storage without reset so it maps onto a RAM with registered read
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
    if (pop_req) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + PTR_W'(1);
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/slr_status.sv
module slr_status
  import serial_lite_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_wr,
  input  logic              stat_rd,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic              ie_nxt,
  output logic [DATA_W-1:0] stat_word,
  output logic              irq
);
  logic pend_q;
  logic pend_n;

  assign pend_n = tx_wr || (cnt_nxt != '0) || (pend_q && !stat_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      pend_q <= pend_n;
      irq    <= pend_n && ie_nxt;
    end
  end

  always_comb begin
    stat_word             = '0;
    stat_word[ST_VALID]   = (cnt != '0);
    stat_word[ST_FULL]    = (cnt == CNT_W'(DEPTH));
    stat_word[ST_TXEMPTY] = 1'b1;
    stat_word[ST_PEND]    = pend_q;
  end
endmodule

// File: rtl/serial_lite_regs.sv
module serial_lite_regs
  import serial_lite_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_strobe,
  output logic              irq,
  output logic              wr_err
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  reg_idx_e          idx;
  reg_idx_e          sel_q;
  logic              wr_tx, wr_stat, wr_ctrl, rd_rx, rd_stat, rx_clr;
  logic [DATA_W-1:0] ctrl_q, ctrl_nxt, txd_q, rdata_q, stat_word;
  logic [BYTE_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  rx_cnt, cnt_nxt;

  assign idx      = reg_idx_e'(bus_addr[ADDR_W-1:2]);
  assign wr_tx    = bus_wr && (idx == REG_TXD);
  assign wr_stat  = bus_wr && (idx == REG_STAT);
  assign wr_ctrl  = bus_wr && (idx == REG_CTRL);
  assign rd_rx    = bus_rd && (idx == REG_RXD);
  assign rd_stat  = bus_rd && (idx == REG_STAT);
  assign ctrl_nxt = wr_ctrl ? bus_wdata : ctrl_q;
  assign rx_clr   = wr_ctrl && bus_wdata[CT_RXRST];

  slr_rx_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .clr     (rx_clr),
    .push    (rx_valid),
    .din     (rx_byte),
    .pop_req (rd_rx),
    .dout    (fifo_dout),
    .cnt     (rx_cnt),
    .cnt_nxt (cnt_nxt),
    .ready   (rx_ready)
  );

  slr_status #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .tx_wr     (wr_tx),
    .stat_rd   (rd_stat),
    .cnt       (rx_cnt),
    .cnt_nxt   (cnt_nxt),
    .ie_nxt    (ctrl_nxt[CT_IE]),
    .stat_word (stat_word),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      txd_q     <= '0;
      tx_byte   <= '0;
      tx_strobe <= 1'b0;
      wr_err    <= 1'b0;
      sel_q     <= REG_STAT;
      rdata_q   <= '0;
    end else begin
      ctrl_q    <= ctrl_nxt;
      tx_strobe <= wr_tx;
      wr_err    <= wr_stat;
      if (wr_tx) begin
        tx_byte <= bus_wdata[BYTE_W-1:0];
        txd_q   <= bus_wdata;
      end
      if (bus_rd) begin
        sel_q <= idx;
        case (idx)
          REG_TXD:  rdata_q <= txd_q;
          REG_STAT: rdata_q <= stat_word;
          REG_CTRL: rdata_q <= ctrl_q;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = (sel_q == REG_RXD) ? {{(DATA_W-BYTE_W){1'b0}}, fifo_dout} : rdata_q;
endmodule

// File: rtl/serial_lite_regs_chk.sv
module serial_lite_regs_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [31:0]      bus_wdata,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [7:0]       tx_byte,
  input logic             tx_strobe,
  input logic             irq,
  input logic             wr_err,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             ie
);
  logic ctrl_w, pop_w, push_w;
  assign ctrl_w = bus_wr && (bus_addr[3:2] == 2'd3);
  assign pop_w  = bus_rd && (bus_addr[3:2] == 2'd0);
  assign push_w = rx_valid && rx_ready;

  a_r8_tx_strobe: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[3:2] == 2'd1) |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));
  a_r8_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr[3:2] == 2'd1) |=> !tx_strobe);
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[3:2] == 2'd2) |=> wr_err);
  a_r11_err_only: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr[3:2] == 2'd2) |=> !wr_err);
  a_r4_bound: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CNT_W'(DEPTH));
  a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == CNT_W'(DEPTH) && !pop_w && !ctrl_w) |=> (rx_cnt == CNT_W'(DEPTH)));
  a_r6_push_pop: assert property (@(posedge clk) disable iff (rst)
    (push_w && pop_w && rx_cnt != '0 && !ctrl_w) |=> $stable(rx_cnt));
  a_r10_irq_on_rx: assert property (@(posedge clk) disable iff (rst)
    (push_w && ie && !ctrl_w) |=> irq);
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (!ie && !ctrl_w) |=> !irq);
endmodule

bind serial_lite_regs serial_lite_regs_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_byte   (tx_byte),
  .tx_strobe (tx_strobe),
  .irq       (irq),
  .wr_err    (wr_err),
  .rx_cnt    (rx_cnt),
  .ie        (ctrl_q[serial_lite_pkg::CT_IE])
);

// File: tb/serial_lite_regs_test.sv
module serial_lite_regs_test;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_byte;
  logic        tx_strobe, irq, wr_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // requirement-level model of the receive buffer
  logic [7:0] sh [D];
  bit         known [D];
  int         mwp  = 0;
  int         mcnt = 0;

  always #4 clk = ~clk;

  serial_lite_regs uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_byte(tx_byte), .tx_strobe(tx_strobe), .irq(irq), .wr_err(wr_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic mclr();
    mwp = 0; mcnt = 0;
  endtask

  task automatic push_b(input logic [7:0] b);
    @(negedge clk);
    chk(rx_ready == (mcnt < D), "R4 rx_ready", 32'(rx_ready), 32'(mcnt < D));
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    if (mcnt < D) begin
      sh[mwp] = b; known[mwp] = 1'b1; mwp = (mwp + 1) % D; mcnt++;
    end
  endtask

  task automatic pop_chk(input string tag);
    logic [31:0] d;
    logic [7:0]  e;
    e = sh[(mwp - mcnt + D) % D];
    rd(4'h0, d);
    chk(d == {24'h0, e}, tag, d, {24'h0, e});
    if (mcnt > 0) mcnt--;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] e;
    for (int i = 0; i < D; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk(irq == 1'b0, "R12 irq", 32'(irq), 0);
    chk(rx_ready == 1'b1, "R12 ready", 32'(rx_ready), 1);
    rd(4'h8, d); chk(d == 32'h4, "R12 status", d, 32'h4);
    rd(4'hC, d); chk(d == 32'h0, "R12 control", d, 32'h0);

    // R1 low address bits ignored
    wr(4'hD, 32'hA5A5_0020); rd(4'hE, d); chk(d == 32'hA5A5_0020, "R1 ctrl alias", d, 32'hA5A5_0020);
    wr(4'h7, 32'h0000_1111); rd(4'h4, d); chk(d == 32'h0000_1111, "R1 tx alias", d, 32'h0000_1111);
    rd(4'hB, d); chk(d == 32'h14, "R1 status alias", d, 32'h14);

    // sweep every fill level at every pointer offset: R2 R3 R4 R5 R9
    for (int off = 0; off < D; off++) begin
      for (int k = 0; k <= D; k++) begin
        wr(4'hC, 32'h2); mclr();
        for (int i = 0; i < off; i++) begin
          push_b(8'(8'hE0 + i)); pop_chk("R3 offset pop");
        end
        rd(4'h8, d);
        for (int i = 0; i < k; i++) push_b(8'((off * 37 + k * 11 + i * 5 + 1) & 255));
        rd(4'h8, d);
        e = 32'h4 | ((k != 0) ? 32'h11 : 32'h0) | ((k == D) ? 32'h2 : 32'h0);
        chk(d == e, "R2 status fill", d, e);
        if (k == D) push_b(8'h5A);
        for (int i = 0; i < k; i++) pop_chk("R3 order");
        if (known[mwp]) begin
          e = {24'h0, sh[mwp]};
          rd(4'h0, d); chk(d == e, "R5 stale read", d, e);
        end
        rd(4'h8, d);
        e = (k != 0) ? 32'h14 : 32'h4;
        chk(d == e, "R9 sticky then clear", d, e);
        rd(4'h8, d); chk(d == 32'h4, "R5 R9 empty after", d, 32'h4);
      end
    end

    // R6 simultaneous pop and push
    wr(4'hC, 32'h2); mclr(); rd(4'h8, d);
    push_b(8'h11); push_b(8'h22);
    @(negedge clk); bus_addr = 4'h0; bus_rd = 1'b1; rx_byte = 8'h33; rx_valid = 1'b1;
    @(negedge clk); bus_rd = 1'b0; rx_valid = 1'b0; d = bus_rdata;
    chk(d == 32'h11, "R6 pop data", d, 32'h11);
    sh[mwp] = 8'h33; known[mwp] = 1'b1; mwp = (mwp + 1) % D; // count stays 2
    pop_chk("R6 second"); pop_chk("R6 pushed byte");
    rd(4'h8, d); chk(d[0] == 1'b0, "R6 empty", d, 32'h0);

    // R4 R6 full: pop happens, concurrent offer dropped
    wr(4'hC, 32'h2); mclr();
    for (int i = 0; i < D; i++) push_b(8'(8'h40 + i));
    @(negedge clk);
    chk(rx_ready == 1'b0, "R4 full ready", 32'(rx_ready), 0);
    bus_addr = 4'h0; bus_rd = 1'b1; rx_byte = 8'hEE; rx_valid = 1'b1;
    @(negedge clk); bus_rd = 1'b0; rx_valid = 1'b0; d = bus_rdata;
    chk(d == 32'h40, "R4 full pop", d, 32'h40); mcnt--;
    chk(rx_ready == 1'b1, "R4 ready after pop", 32'(rx_ready), 1);
    for (int i = 1; i < D; i++) pop_chk("R4 drop order");
    rd(4'h8, d); chk(d == 32'h14, "R4 empty status", d, 32'h14);

    // R7 control clear and readback; R10 irq
    push_b(8'h01); push_b(8'h02); push_b(8'h03);
    chk(irq == 1'b0, "R10 masked", 32'(irq), 0);
    wr(4'hC, 32'h0000_0012); mclr();
    chk(irq == 1'b1, "R10 enable applies", 32'(irq), 1);
    rd(4'hC, d); chk(d == 32'h12, "R7 readback", d, 32'h12);
    chk(rx_ready == 1'b1, "R7 ready", 32'(rx_ready), 1);
    rd(4'h8, d); chk(d == 32'h14, "R7 cleared status", d, 32'h14);
    chk(irq == 1'b0, "R10 clear on status read", 32'(irq), 0);
    push_b(8'h77);
    chk(irq == 1'b1, "R10 one edge after push", 32'(irq), 1);
    pop_chk("R7 data after clear");
    chk(irq == 1'b1, "R10 sticky after drain", 32'(irq), 1);
    wr(4'hC, 32'h0);
    chk(irq == 1'b0, "R10 disable", 32'(irq), 0);
    rd(4'h8, d); chk(d == 32'h14, "R9 pending while masked", d, 32'h14);

    // R8 transmit
    wr(4'hC, 32'h10);
    chk(irq == 1'b0, "R10 idle", 32'(irq), 0);
    wr(4'h4, 32'h1234_56A5);
    chk(tx_strobe == 1'b1, "R8 strobe", 32'(tx_strobe), 1);
    chk(tx_byte == 8'hA5, "R8 byte", 32'(tx_byte), 32'hA5);
    chk(irq == 1'b1, "R8 R10 tx pending", 32'(irq), 1);
    @(negedge clk);
    chk(tx_strobe == 1'b0, "R8 one cycle", 32'(tx_strobe), 0);
    rd(4'h4, d); chk(d == 32'h1234_56A5, "R8 readback", d, 32'h1234_56A5);
    rd(4'h8, d); chk(d == 32'h14, "R8 status pending", d, 32'h14);
    chk(irq == 1'b0, "R9 cleared", 32'(irq), 0);

    // R11 status write ignored
    wr(4'h8, 32'hFFFF_FFFF);
    chk(wr_err == 1'b1, "R11 pulse", 32'(wr_err), 1);
    chk(irq == 1'b0, "R11 no irq", 32'(irq), 0);
    @(negedge clk);
    chk(wr_err == 1'b0, "R11 one cycle", 32'(wr_err), 0);
    rd(4'h8, d); chk(d == 32'h4, "R11 status unchanged", d, 32'h4);
    rd(4'hC, d); chk(d == 32'h10, "R11 control unchanged", d, 32'h10);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule